// File: doc/BRIEF.md
# Disk Channel Program Sequencer

This block runs disk channel programs on its own. A channel program is a chain of orders held in a 16-bit word memory. Software loads the starting order address with a programmed-I/O output strobe, and the sequencer then fetches and executes orders without further help. Each order is two or three words long. While it runs, the sequencer sends unit-select, seek and transfer commands to a drive port. It loads DMA channel settings, stores its status word or its order address back into memory, posts a vectored interrupt, waits for a fixed delay, jumps, or halts, as each order directs. Data movement and the drive mechanics belong to other blocks.

The controller has seven states. `ST_HALT` is idle; the sequencer sits there after reset and after a halt order or an unknown opcode. `ST_FETCH` issues the read of the first order word. `ST_WORD0` takes in the first word. If that word has the conditional bit set, the order is skipped and the state goes back to `ST_FETCH`; otherwise the second word is requested. `ST_WORD1` takes in the second word and either requests the third word (going to `ST_WORD2`) or moves to `ST_EXEC`. `ST_WORD2` takes in the third word and moves to `ST_EXEC`. `ST_EXEC` performs the order in one cycle and then goes to `ST_FETCH`, `ST_STALL` or `ST_HALT`. `ST_STALL` counts down a fixed delay and then returns to `ST_FETCH`. A load strobe sends any state to `ST_FETCH`.

Memory is a synchronous port. Read data appears in the cycle after `mem_rd`, and a write completes at the edge on which `mem_we` is high.

Top module: `chan_seq`

## Requirements
- R1: After reset the sequencer is halted, the order address is 0, the status word is 0x8000, and no interrupt is requested.
- R2: An output strobe with function 6'o17 loads `pio_wdata` into the order address and acknowledges (`pio_skip`=1). In the next cycle the sequencer reads memory at that address.
- R3: An order whose first word has bit 11 set is skipped without any effect, and the order address still advances by the order length. Opcodes 2, 5 and 6 are three words long; every other opcode is two words long.
- R4: Opcodes 2 (format), 5 (read) and 6 (write) pulse `xfer_stb` for one cycle. `xfer_op` carries the opcode and `xfer_rec_size` carries word0[3:0]. `xfer_rec_addr` = track×HEADS×SPT + head×SPT + record, where track = word1[9:0], head = word2[5:0] and record = word2[15:8].
- R5: Opcode 4 pulses `drv_sel_stb` with unit word1[3:1]; an encoded value of 4 is sent as unit 3. If `drv_ready` is low in that cycle, the status becomes 0x8001 and the unit is marked not ready. Otherwise the status becomes 0x8000.
- R6: Opcode 3 pulses `drv_seek_stb` with `drv_track`=word1[9:0], `drv_restore`=word1[15] and `drv_clear`=word1[14].
- R7: Opcode 9 writes the status word to the address in word 1. Opcode 11 writes the current order address, which already points past the storing order, to the address in word 1.
- R8: Opcode 15 continues execution at the address in word 1. Opcode 0 halts, and the order address is left pointing past the halt order.
- R9: Opcode 13 sets `dma_cnt_m1` to word0[3:0] and `dma_first` to word1.
- R10: Opcode 14 with no interrupt pending raises `irq_req` with `irq_vec`=word1. Both hold until `irq_ack`. The sequencer then pauses for STALL_CYC cycles.
- R11: Opcode 7 pauses the sequencer for exactly STALL_CYC cycles before it fetches the next order.
- R12: An input strobe with function 6'o17 returns the order address with `pio_skip`=1 only while halted; while running, `pio_skip` is 0. Function 6'o01 returns 0x40+DEV_NUM. Function 6'o11 returns `pio_wdata` OR'ed with 0x40+DEV_NUM. Both of these acknowledge.
- R13: Opcode 14 while an interrupt is pending leaves the vector unchanged and sets status bit 1. Any opcode in {1, 8, 10, 12} sets status bit 1 and halts.
- R14: A transfer order issued while no ready unit is selected pulses nothing and sets the status to 0x8001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pio_out_stb | input | 1 | Programmed-I/O output strobe |
| pio_in_stb | input | 1 | Programmed-I/O input strobe |
| pio_func | input | 6 | Programmed-I/O function code |
| pio_wdata | input | 16 | Output data / accumulator value |
| pio_rdata | output | 16 | Input data returned |
| pio_skip | output | 1 | Function accepted |
| mem_rd | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_rd` |
| drv_sel_stb | output | 1 | Unit select pulse |
| drv_unit | output | 2 | Selected unit |
| drv_ready | input | 1 | Selected unit is ready |
| drv_seek_stb | output | 1 | Seek pulse |
| drv_track | output | 10 | Seek track |
| drv_restore | output | 1 | Seek restore request |
| drv_clear | output | 1 | Seek clear request |
| xfer_stb | output | 1 | Transfer command pulse |
| xfer_op | output | 4 | Transfer opcode (2, 5 or 6) |
| xfer_rec_addr | output | REC_W | Physical record address |
| xfer_rec_size | output | 4 | Record size field |
| dma_cnt_m1 | output | 4 | DMA channel count minus one |
| dma_first | output | 16 | First DMA channel |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 16 | Interrupt vector |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
A table of transfer orders drives the record-address path. It includes the all-zero corner, the maximum track/head/record corner, and ordinary mid-range values, and each opcode is checked to reach `xfer_op` unchanged. Separate directed programs each exercise one kind of order: select with a ready unit and with a not-ready unit, seek, jump, DMA setup, store, and conditional skips of two-word and three-word orders. Each check tells whether the order length and the order-address advance are right. Two programs that differ only by a stall order show the exact length of the pause. Back-to-back interrupt orders show that a pending vector is never overwritten. A bad opcode followed by a status store shows that the error bit survives the halt.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
    typedef enum logic [2:0] {
        ST_HALT, ST_FETCH, ST_WORD0, ST_WORD1, ST_WORD2, ST_EXEC, ST_STALL
    } seq_state_t;

    localparam logic [3:0] OP_HALT  = 4'd0;
    localparam logic [3:0] OP_FMT   = 4'd2;
    localparam logic [3:0] OP_SEEK  = 4'd3;
    localparam logic [3:0] OP_SEL   = 4'd4;
    localparam logic [3:0] OP_READ  = 4'd5;
    localparam logic [3:0] OP_WRITE = 4'd6;
    localparam logic [3:0] OP_STALL = 4'd7;
    localparam logic [3:0] OP_STAT  = 4'd9;
    localparam logic [3:0] OP_SOAR  = 4'd11;
    localparam logic [3:0] OP_DMA   = 4'd13;
    localparam logic [3:0] OP_INT   = 4'd14;
    localparam logic [3:0] OP_JUMP  = 4'd15;

    localparam logic [15:0] STAT_OK    = 16'h8000;
    localparam logic [15:0] STAT_NRDY  = 16'h8001;
    localparam int          STAT_ERR_B = 1;
    localparam logic [5:0]  FN_ID_CLR  = 6'o01;
    localparam logic [5:0]  FN_ID_OR   = 6'o11;
    localparam logic [5:0]  FN_OAR     = 6'o17;
endpackage

// File: rtl/chan_len_dec.sv
module chan_len_dec
    import chan_seq_pkg::*;
(
    input  logic [3:0] op,
    output logic       three,
    output logic       legal,
    output logic       is_xfer
);
    always_comb begin
        is_xfer = (op == OP_FMT) || (op == OP_READ) || (op == OP_WRITE);
        three   = is_xfer;
        unique case (op)
            4'd1, 4'd8, 4'd10, 4'd12: legal = 1'b0;
            default:                  legal = 1'b1;
        endcase
    end
endmodule

// File: rtl/chan_recaddr.sv
module chan_recaddr #(
    parameter int HEADS = 40,
    parameter int SPT   = 9,
    parameter int REC_W = 24
) (
    input  logic [9:0]       track,
    input  logic [5:0]       head,
    input  logic [7:0]       rec,
    output logic [REC_W-1:0] addr
);
    localparam int TRK_STEP = HEADS * SPT;

    always_comb begin
        addr = REC_W'(track) * REC_W'(TRK_STEP)
             + REC_W'(head)  * REC_W'(SPT)
             + REC_W'(rec);
    end
endmodule

// File: rtl/chan_pio.sv
module chan_pio
    import chan_seq_pkg::*;
#(
    parameter logic [5:0] DEV_NUM = 6'o26
) (
    input  logic        out_stb,
    input  logic        in_stb,
    input  logic [5:0]  func,
    input  logic [15:0] wdata,
    input  logic        halted,
    input  logic [15:0] oar,
    output logic [15:0] rdata,
    output logic        skip,
    output logic        load
);
    localparam logic [15:0] ID_WORD = 16'h0040 + 16'(DEV_NUM);

    always_comb begin
        rdata = '0;
        skip  = 1'b0;
        load  = out_stb && (func == FN_OAR);
        if (load) begin
            skip = 1'b1;
        end else if (in_stb) begin
            unique case (func)
                FN_ID_CLR: begin rdata = ID_WORD;         skip = 1'b1; end
                FN_ID_OR:  begin rdata = wdata | ID_WORD; skip = 1'b1; end
                FN_OAR:    begin rdata = halted ? oar : 16'h0; skip = halted; end
                default:   begin rdata = '0; skip = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/chan_seq.sv
module chan_seq
    import chan_seq_pkg::*;
#(
    parameter logic [5:0] DEV_NUM   = 6'o26,
    parameter int         HEADS     = 40,
    parameter int         SPT       = 9,
    parameter int         STALL_CYC = 8,
    parameter int         REC_W     = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pio_out_stb,
    input  logic             pio_in_stb,
    input  logic [5:0]       pio_func,
    input  logic [15:0]      pio_wdata,
    output logic [15:0]      pio_rdata,
    output logic             pio_skip,
    output logic             mem_rd,
    output logic             mem_we,
    output logic [15:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    output logic             drv_sel_stb,
    output logic [1:0]       drv_unit,
    input  logic             drv_ready,
    output logic             drv_seek_stb,
    output logic [9:0]       drv_track,
    output logic             drv_restore,
    output logic             drv_clear,
    output logic             xfer_stb,
    output logic [3:0]       xfer_op,
    output logic [REC_W-1:0] xfer_rec_addr,
    output logic [3:0]       xfer_rec_size,
    output logic [3:0]       dma_cnt_m1,
    output logic [15:0]      dma_first,
    output logic             irq_req,
    output logic [15:0]      irq_vec,
    input  logic             irq_ack
);
    localparam int CNT_W = (STALL_CYC > 1) ? $clog2(STALL_CYC) : 1;

    seq_state_t       state, state_nx;
    logic [15:0]      oar;
    logic [15:0]      w0, w1, w2;
    logic [15:0]      status;
    logic             unit_ok;
    logic [CNT_W-1:0] stall_cnt;
    logic             pio_load;

    logic [3:0] op;
    logic       op_three, op_legal, op_xfer;
    logic       rd_three, rd_legal, rd_xfer;
    logic [2:0] sel_enc;

    assign op      = w0[15:12];
    assign sel_enc = w1[3:1];

    chan_len_dec u_dec_exec (
        .op(op), .three(op_three), .legal(op_legal), .is_xfer(op_xfer)
    );

    chan_len_dec u_dec_mem (
        .op(mem_rdata[15:12]), .three(rd_three), .legal(rd_legal), .is_xfer(rd_xfer)
    );

    chan_recaddr #(.HEADS(HEADS), .SPT(SPT), .REC_W(REC_W)) u_rec (
        .track(w1[9:0]), .head(w2[5:0]), .rec(w2[15:8]), .addr(xfer_rec_addr)
    );

    chan_pio #(.DEV_NUM(DEV_NUM)) u_pio (
        .out_stb(pio_out_stb), .in_stb(pio_in_stb), .func(pio_func),
        .wdata(pio_wdata), .halted(state == ST_HALT), .oar(oar),
        .rdata(pio_rdata), .skip(pio_skip), .load(pio_load)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:  state_nx = ST_HALT;
            ST_FETCH: state_nx = ST_WORD0;
            ST_WORD0: state_nx = mem_rdata[11] ? ST_FETCH : ST_WORD1;
            ST_WORD1: state_nx = op_three ? ST_WORD2 : ST_EXEC;
            ST_WORD2: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (!op_legal || op == OP_HALT)            state_nx = ST_HALT;
                else if (op == OP_STALL)                   state_nx = ST_STALL;
                else if (op == OP_INT && !irq_req)         state_nx = ST_STALL;
                else                                       state_nx = ST_FETCH;
            end
            ST_STALL: state_nx = (stall_cnt == '0) ? ST_FETCH : ST_STALL;
            default:  state_nx = ST_HALT;
        endcase
        if (pio_load) state_nx = ST_FETCH;
    end

    // outputs
    always_comb begin
        mem_rd        = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = oar;
        mem_wdata     = oar;
        drv_sel_stb   = 1'b0;
        drv_seek_stb  = 1'b0;
        xfer_stb      = 1'b0;
        drv_unit      = (sel_enc == 3'd4) ? 2'd3 : sel_enc[1:0];
        drv_track     = w1[9:0];
        drv_restore   = w1[15];
        drv_clear     = w1[14];
        xfer_op       = op;
        xfer_rec_size = w0[3:0];
        unique case (state)
            ST_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = oar;
            end
            ST_WORD0: begin
                mem_rd   = !mem_rdata[11];
                mem_addr = oar + 16'd1;
            end
            ST_WORD1: begin
                mem_rd   = op_three;
                mem_addr = oar + 16'd2;
            end
            ST_EXEC: begin
                mem_addr     = w1;
                mem_we       = (op == OP_STAT) || (op == OP_SOAR);
                mem_wdata    = (op == OP_STAT) ? status : oar;
                drv_sel_stb  = (op == OP_SEL);
                drv_seek_stb = (op == OP_SEEK);
                xfer_stb     = op_xfer && unit_ok;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oar        <= '0;
            w0         <= '0;
            w1         <= '0;
            w2         <= '0;
            status     <= STAT_OK;
            unit_ok    <= 1'b0;
            stall_cnt  <= '0;
            dma_cnt_m1 <= '0;
            dma_first  <= '0;
            irq_req    <= 1'b0;
            irq_vec    <= '0;
        end else begin
            if (irq_ack) irq_req <= 1'b0;
            unique case (state)
                ST_WORD0: begin
                    w0 <= mem_rdata;
                    if (mem_rdata[11])
                        oar <= oar + (rd_three ? 16'd3 : 16'd2);
                end
                ST_WORD1: begin
                    w1 <= mem_rdata;
                    if (!op_three) oar <= oar + 16'd2;
                end
                ST_WORD2: begin
                    w2  <= mem_rdata;
                    oar <= oar + 16'd3;
                end
                ST_EXEC: begin
                    if (!op_legal) status[STAT_ERR_B] <= 1'b1;
                    unique case (op)
                        OP_SEL: begin
                            unit_ok <= drv_ready;
                            status  <= drv_ready ? STAT_OK : STAT_NRDY;
                        end
                        OP_FMT, OP_READ, OP_WRITE:
                            if (!unit_ok) status <= STAT_NRDY;
                        OP_STALL: stall_cnt <= CNT_W'(STALL_CYC - 1);
                        OP_DMA: begin
                            dma_cnt_m1 <= w0[3:0];
                            dma_first  <= w1;
                        end
                        OP_INT: begin
                            if (irq_req) begin
                                status[STAT_ERR_B] <= 1'b1;
                            end else begin
                                irq_req   <= 1'b1;
                                irq_vec   <= w1;
                                stall_cnt <= CNT_W'(STALL_CYC - 1);
                            end
                        end
                        OP_JUMP: oar <= w1;
                        default: ;
                    endcase
                end
                ST_STALL: if (stall_cnt != '0) stall_cnt <= stall_cnt - 1'b1;
                default: ;
            endcase
            if (pio_load) oar <= pio_wdata;
        end
    end
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pio_out_stb,
    input logic        pio_in_stb,
    input logic [5:0]  pio_func,
    input logic [15:0] pio_wdata,
    input logic        pio_skip,
    input logic        mem_rd,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        drv_sel_stb,
    input logic        drv_seek_stb,
    input logic        xfer_stb,
    input logic        irq_req,
    input logic [15:0] irq_vec,
    input logic        irq_ack
);
    // R2
    start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_out_stb && pio_func == 6'o17) |=> (mem_rd && mem_addr == $past(pio_wdata)));

    // R4
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_we, drv_sel_stb, drv_seek_stb, xfer_stb}));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    // R12
    busy_noskip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_rd) && pio_in_stb && !pio_out_stb && pio_func == 6'o17) |-> !pio_skip);
endmodule

bind chan_seq chan_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pio_out_stb(pio_out_stb), .pio_in_stb(pio_in_stb),
    .pio_func(pio_func), .pio_wdata(pio_wdata), .pio_skip(pio_skip),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .drv_sel_stb(drv_sel_stb), .drv_seek_stb(drv_seek_stb), .xfer_stb(xfer_stb),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
);

// File: tb/chan_seq_tb.sv
module chan_seq_tb;
    localparam int HEADS = 40;
    localparam int SPT   = 9;
    localparam int STALL = 8;
    localparam int REC_W = 24;
    localparam logic [5:0] DEV = 6'o26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pio_out_stb = 1'b0, pio_in_stb = 1'b0;
    logic [5:0] pio_func = '0;
    logic [15:0] pio_wdata = '0;
    logic [15:0] pio_rdata;
    logic pio_skip;
    logic mem_rd, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic drv_sel_stb, drv_seek_stb, drv_restore, drv_clear, xfer_stb;
    logic [1:0] drv_unit;
    logic [9:0] drv_track;
    logic [3:0] xfer_op, xfer_rec_size, dma_cnt_m1;
    logic [REC_W-1:0] xfer_rec_addr;
    logic [15:0] dma_first, irq_vec;
    logic irq_req;
    logic irq_ack = 1'b0;
    logic [3:0] ready_mask = 4'b1111;
    logic drv_ready;

    assign drv_ready = ready_mask[drv_unit];

    always #2.5 clk = ~clk;

    chan_seq #(.DEV_NUM(DEV), .HEADS(HEADS), .SPT(SPT), .STALL_CYC(STALL), .REC_W(REC_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pio_out_stb(pio_out_stb), .pio_in_stb(pio_in_stb), .pio_func(pio_func),
        .pio_wdata(pio_wdata), .pio_rdata(pio_rdata), .pio_skip(pio_skip),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .drv_sel_stb(drv_sel_stb), .drv_unit(drv_unit), .drv_ready(drv_ready),
        .drv_seek_stb(drv_seek_stb), .drv_track(drv_track), .drv_restore(drv_restore),
        .drv_clear(drv_clear), .xfer_stb(xfer_stb), .xfer_op(xfer_op),
        .xfer_rec_addr(xfer_rec_addr), .xfer_rec_size(xfer_rec_size),
        .dma_cnt_m1(dma_cnt_m1), .dma_first(dma_first),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    // memory and event monitors
    logic [15:0] mem [256];
    int cyc = 0, we_cyc = 0;
    int xfer_cnt = 0, sel_cnt = 0, seek_cnt = 0;
    logic [3:0] l_op, l_size;
    logic [REC_W-1:0] l_rec;
    logic [1:0] l_unit;
    logic [9:0] l_track;
    logic l_rst, l_clr;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            we_cyc <= cyc;
        end
        if (xfer_stb) begin
            xfer_cnt <= xfer_cnt + 1;
            l_op <= xfer_op; l_size <= xfer_rec_size; l_rec <= xfer_rec_addr;
        end
        if (drv_sel_stb) begin sel_cnt <= sel_cnt + 1; l_unit <= drv_unit; end
        if (drv_seek_stb) begin
            seek_cnt <= seek_cnt + 1;
            l_track <= drv_track; l_rst <= drv_restore; l_clr <= drv_clear;
        end
    end

    int tests = 0, fails = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pio_in(input logic [5:0] f, input logic [15:0] a,
                          output logic [15:0] d, output logic s);
        @(negedge clk);
        pio_in_stb = 1'b1; pio_func = f; pio_wdata = a;
        #1;
        d = pio_rdata; s = pio_skip;
        pio_in_stb = 1'b0;
    endtask

    task automatic start(input logic [15:0] a);
        @(negedge clk);
        pio_out_stb = 1'b1; pio_func = 6'o17; pio_wdata = a;
        @(negedge clk);
        pio_out_stb = 1'b0;
    endtask

    task automatic run(input logic [15:0] a, output logic [15:0] fin);
        logic [15:0] d;
        logic s;
        start(a);
        fin = 16'hFFFF;
        for (int i = 0; i < 400; i++) begin
            pio_in(6'o17, 16'h0, d, s);
            if (s) begin fin = d; break; end
        end
    endtask

    // transfer table: {op, size, track, head, rec}
    localparam logic [31:0] XV [5] = '{
        {4'd5, 4'd0,  10'd0,    6'd0,  8'd0},
        {4'd5, 4'd4,  10'd5,    6'd3,  8'd7},
        {4'd2, 4'd2,  10'd1023, 6'd63, 8'd255},
        {4'd6, 4'd9,  10'd100,  6'd39, 8'd8},
        {4'd5, 4'd15, 10'd1,    6'd0,  8'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d, fin;
        logic s;
        int c1, c2, base;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        do_reset();

        // R1 reset state
        pio_in(6'o17, 16'h0, d, s);
        check("R1 halted skip", {31'd0, s}, 32'd1);
        check("R1 oar", {16'd0, d}, 32'h0);
        check("R1 irq", {31'd0, irq_req}, 32'd0);
        mem[8'hC6] = 16'h9000; mem[8'hC7] = 16'h00E7; mem[8'hC8] = 16'h0000;
        run(16'h00C6, fin);
        check("R1 status", {16'd0, mem[8'hE7]}, 32'h8000);

        // R12 identity reads
        pio_in(6'o01, 16'h1234, d, s);
        check("R12 id", {15'd0, s, d}, {15'd0, 1'b1, 16'h0056});
        pio_in(6'o11, 16'h8000, d, s);
        check("R12 id or", {15'd0, s, d}, {15'd0, 1'b1, 16'h8056});

        // R4 transfer table
        for (int k = 0; k < 5; k++) begin
            logic [3:0] op, sz;
            logic [9:0] tr;
            logic [5:0] hd;
            logic [7:0] rc;
            int n0;
            {op, sz, tr, hd, rc} = XV[k];
            mem[8'h20] = 16'h4000; mem[8'h21] = 16'h0000;
            mem[8'h22] = {op, 8'h00, sz};
            mem[8'h23] = {6'd0, tr};
            mem[8'h24] = {rc, 2'b00, hd};
            mem[8'h25] = 16'h0000; mem[8'h26] = 16'h0000;
            n0 = xfer_cnt;
            run(16'h0020, fin);
            check("R4 xfer count", xfer_cnt - n0, 1);
            check("R4 op", {28'd0, l_op}, {28'd0, op});
            check("R4 size", {28'd0, l_size}, {28'd0, sz});
            check("R4 recaddr", {8'd0, l_rec}, tr * HEADS * SPT + hd * SPT + rc);
            check("R8 halt oar", {16'd0, fin}, 32'h27);
        end

        // R2 start and readback after DMA order; R9 DMA fields
        mem[8'hC0] = 16'hD003; mem[8'hC1] = 16'h0123;
        mem[8'hC2] = 16'h0000; mem[8'hC3] = 16'h0000;
        run(16'h00C0, fin);
        check("R2 oar after run", {16'd0, fin}, 32'hC4);
        check("R9 dma cnt", {28'd0, dma_cnt_m1}, 32'd3);
        check("R9 dma first", {16'd0, dma_first}, 32'h0123);

        // R5 / R14 select of not-ready unit 3 (encoded 4)
        ready_mask = 4'b0111;
        base = xfer_cnt;
        mem[8'h60] = 16'h4000; mem[8'h61] = 16'h0008;
        mem[8'h62] = 16'h9000; mem[8'h63] = 16'h00E0;
        mem[8'h64] = 16'h5000; mem[8'h65] = 16'h0003; mem[8'h66] = 16'h0102;
        mem[8'h67] = 16'h9000; mem[8'h68] = 16'h00E1;
        mem[8'h69] = 16'h0000; mem[8'h6A] = 16'h0000;
        run(16'h0060, fin);
        check("R5 unit map", {30'd0, l_unit}, 32'd3);
        check("R5 not ready status", {16'd0, mem[8'hE0]}, 32'h8001);
        check("R14 no xfer", xfer_cnt - base, 0);
        check("R14 status", {16'd0, mem[8'hE1]}, 32'h8001);
        mem[8'h70] = 16'h4000; mem[8'h71] = 16'h0002;
        mem[8'h72] = 16'h9000; mem[8'h73] = 16'h00E2;
        mem[8'h74] = 16'h0000; mem[8'h75] = 16'h0000;
        run(16'h0070, fin);
        check("R5 unit1", {30'd0, l_unit}, 32'd1);
        check("R5 ready status", {16'd0, mem[8'hE2]}, 32'h8000);
        ready_mask = 4'b1111;

        // R6 seek
        mem[8'h80] = 16'h3000; mem[8'h81] = 16'hC155;
        mem[8'h82] = 16'h0000; mem[8'h83] = 16'h0000;
        run(16'h0080, fin);
        check("R6 seek", {20'd0, l_rst, l_clr, l_track}, {20'd0, 1'b1, 1'b1, 10'h155});

        // R3 conditional skips of a 3-word and a 2-word order; R7 store oar
        base = xfer_cnt; c1 = seek_cnt;
        mem[8'h90] = 16'h5800; mem[8'h91] = 16'h0001; mem[8'h92] = 16'h0101;
        mem[8'h93] = 16'h3800; mem[8'h94] = 16'h0033;
        mem[8'h95] = 16'hB000; mem[8'h96] = 16'h00E3;
        mem[8'h97] = 16'h0000; mem[8'h98] = 16'h0000;
        run(16'h0090, fin);
        check("R3 skip advance", {16'd0, mem[8'hE3]}, 32'h97);
        check("R3 no effect", (xfer_cnt - base) + (seek_cnt - c1), 0);

        // R8 jump, R7 store oar
        mem[8'hA0] = 16'hF000; mem[8'hA1] = 16'h00B0;
        mem[8'hB0] = 16'hB000; mem[8'hB1] = 16'h00E4;
        mem[8'hB2] = 16'h0000; mem[8'hB3] = 16'h0000;
        run(16'h00A0, fin);
        check("R8 jump", {16'd0, mem[8'hE4]}, 32'hB2);
        check("R8 halt oar", {16'd0, fin}, 32'hB4);

        // R11 stall length and R12 busy readback
        mem[8'h40] = 16'h3000; mem[8'h41] = 16'h0000;
        mem[8'h42] = 16'hB000; mem[8'h43] = 16'h00F0;
        mem[8'h44] = 16'h0000; mem[8'h45] = 16'h0000;
        mem[8'h50] = 16'h7000; mem[8'h51] = 16'h0000;
        mem[8'h52] = 16'hB000; mem[8'h53] = 16'h00F1;
        mem[8'h54] = 16'h0000; mem[8'h55] = 16'h0000;
        start(16'h0040);
        c1 = cyc;
        pio_in(6'o17, 16'h0, d, s);
        check("R12 busy noskip", {31'd0, s}, 32'd0);
        repeat (40) @(negedge clk);
        c1 = we_cyc - c1;
        start(16'h0050);
        c2 = cyc;
        repeat (40) @(negedge clk);
        c2 = we_cyc - c2;
        check("R11 stall cycles", c2 - c1, STALL);
        check("R11 oar after stall", {16'd0, mem[8'hF1]}, 32'h54);

        // R10 / R13 interrupt then overlapping interrupt
        do_reset();
        mem[8'h10] = 16'hE000; mem[8'h11] = 16'h0777;
        mem[8'h12] = 16'hE000; mem[8'h13] = 16'h0555;
        mem[8'h14] = 16'h9000; mem[8'h15] = 16'h00E5;
        mem[8'h16] = 16'h0000; mem[8'h17] = 16'h0000;
        run(16'h0010, fin);
        check("R10 irq req", {31'd0, irq_req}, 32'd1);
        check("R13 vec kept", {16'd0, irq_vec}, 32'h0777);
        check("R13 err status", {16'd0, mem[8'hE5]}, 32'h8002);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check("R10 ack clears", {31'd0, irq_req}, 32'd0);

        // R13 bad opcode
        do_reset();
        mem[8'h30] = 16'h1000; mem[8'h31] = 16'h0000;
        mem[8'h32] = 16'h9000; mem[8'h33] = 16'h00E6;
        run(16'h0030, fin);
        check("R13 bad halts", {16'd0, fin}, 32'h32);
        mem[8'h34] = 16'h9000; mem[8'h35] = 16'h00E6;
        mem[8'h36] = 16'h0000; mem[8'h37] = 16'h0000;
        run(16'h0034, fin);
        check("R13 bad status", {16'd0, mem[8'hE6]}, 32'h8002);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule